// File: doc/BRIEF.md
# Reference Table Operand Resolver

This block carries out the two stack-loading call syllables of a stack processor. The sequencer hands it a 10-bit index into a reference table. The table sits in memory at a relocatable base held in a register, so programs carry only the index. The resolver reads the table word and classifies it from its tag bits. It then loads a plain value, follows a direct pointer, indexes an array, or enters a subroutine. The result is one of three things: a word pushed on the stack, a branch target handed back to the sequencer, or an interrupt.

Each request names one of two call types. An operand call wants the value itself. A descriptor call wants a descriptor that addresses the value. For an array, the index comes from the mantissa of the second stack item. That index is checked against the array size in hardware before any memory access. Entering a program segment that is not present in memory raises an interrupt instead of branching. Each fault latches the table index for the handler.

Word layout:

| Bits | Meaning |
|---|---|
| 47 | Tag: 0 for data, 1 for descriptor |
| 46:45 | Descriptor kind |
| 44 | Present flag |
| 43:34 | Size |
| 33:15 | Reserved, zero |
| 14:0 | Base address |

The descriptor kinds are 00 direct, 01 array, 10 program and 11 handled as direct. The index of an array access is bits 38:0 of the second stack item, read as unsigned.

Top module: `rtr_resolver`

## Requirements
- R1: After reset, req_ready_o is 1, fault_index_o is 0 and push_o, pop_o, branch_o, irq_o, done_o and mem_req_o are 0.
- R2: An accepted request issues exactly one table read, at address table_base_i + req_index_i modulo 2^15. req_ready_o stays 0 until the request completes.
- R3: An operand call on a data entry (bit 47 = 0) pushes the entry unchanged. push_o, done_o and the data are visible 2 clock edges after the accepting edge.
- R4: A descriptor call on a data entry pushes a built descriptor with tag 1, kind 00, present 1, size 0 and base equal to the table address, after 2 edges.
- R5: For a direct descriptor (kind 00), an operand call reads the word at the descriptor base and pushes it after 4 edges. A descriptor call pushes the entry unchanged after 2 edges with no second read.
- R6: For an array descriptor (kind 01) with index < size, the index item is consumed (pop_o with push_o). An operand call pushes the word at base + index after 4 edges. A descriptor call pushes a direct descriptor (tag 1, kind 00, present 1, size 0, base + index) after 2 edges.
- R7: For an array descriptor with index >= size, irq_o pulses with irq_cause_o = 01 after 2 edges. There is no push, no pop and no second read, and fault_index_o takes the table index.
- R8: A present program descriptor (kind 10, present 1) pulses branch_o for one cycle with branch_addr_o equal to its base, for either call type, with no push.
- R9: An absent program descriptor (kind 10, present 0) pulses irq_o with irq_cause_o = 10 and latches the table index in fault_index_o, with no branch.
- R10: fault_index_o and irq_cause_o hold their values through later requests that do not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Call syllable request |
| req_ready_o | output | 1 | Resolver idle, request accepted |
| req_desc_call_i | input | 1 | 1 = descriptor call, 0 = operand call |
| req_index_i | input | 10 | Reference table index |
| table_base_i | input | 15 | Reference table base register |
| stk_index_i | input | 39 | Mantissa of the second stack item, the array index |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 15 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 48 | Read data |
| push_o | output | 1 | Push strobe |
| push_data_o | output | 48 | Word to push |
| pop_o | output | 1 | Consume the index item |
| branch_o | output | 1 | Subroutine entry strobe |
| branch_addr_o | output | 15 | Subroutine base address |
| done_o | output | 1 | Request complete |
| irq_o | output | 1 | Interrupt strobe |
| irq_cause_o | output | 2 | 01 bounds violation, 10 absent segment |
| fault_index_o | output | 10 | Table index of the last fault |

## Verification
The accepting edge is counted as edge 0. The table read strobe is visible after edge 0. Results of one-read paths appear after edge 2: plain pushes, built descriptors, branches and both faults. Two-read paths (direct and array operand fetches) complete after edge 4. The bench counts falling edges from the accepting edge and samples every output there. It demands done_o at exactly the expected count and records each read address it sees along the way.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int WORD_W      = 48;
  localparam int MANT_W      = 39;
  localparam int POS_FLAG    = 47;
  localparam int POS_KIND_LO = 45;
  localparam int POS_PRES    = 44;
  localparam int POS_SIZE_HI = 43;

  typedef enum logic [1:0] {
    KIND_DIRECT = 2'b00,
    KIND_ARRAY  = 2'b01,
    KIND_PROG   = 2'b10,
    KIND_RSVD   = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    ACT_PUSH_ENTRY,
    ACT_PUSH_BUILT,
    ACT_READ_DIRECT,
    ACT_READ_ELEM,
    ACT_PUSH_ELEM_DESC,
    ACT_BRANCH,
    ACT_FAULT_BOUNDS,
    ACT_FAULT_ABSENT
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_DAT_REQ,
    ST_DAT_WAIT
  } state_e;

  localparam logic [1:0] CAUSE_BOUNDS = 2'b01;
  localparam logic [1:0] CAUSE_ABSENT = 2'b10;
endpackage

// File: rtl/rtr_classify.sv
module rtr_classify
  import rtr_pkg::*;
(
  input  logic       flag_i,
  input  logic [1:0] kind_i,
  input  logic       present_i,
  input  logic       desc_call_i,
  input  logic       in_range_i,
  output act_e       act_o
);
  always_comb begin
    if (!flag_i) begin
      act_o = desc_call_i ? ACT_PUSH_BUILT : ACT_PUSH_ENTRY;
    end else begin
      unique case (kind_e'(kind_i))
        KIND_PROG:  act_o = present_i ? ACT_BRANCH : ACT_FAULT_ABSENT;
        KIND_ARRAY: begin
          if (!in_range_i)     act_o = ACT_FAULT_BOUNDS;
          else if (desc_call_i) act_o = ACT_PUSH_ELEM_DESC;
          else                 act_o = ACT_READ_ELEM;
        end
        default:    act_o = desc_call_i ? ACT_PUSH_ENTRY : ACT_READ_DIRECT;
      endcase
    end
  end
endmodule

// File: rtl/rtr_bounds.sv
module rtr_bounds #(
  parameter int IDX_W  = 10,
  parameter int ADDR_W = 15,
  parameter int MANT_W = 39
) (
  input  logic [MANT_W-1:0] index_i,
  input  logic [IDX_W-1:0]  size_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              in_range_o,
  output logic [ADDR_W-1:0] elem_addr_o
);
  localparam int PAD_M = MANT_W - IDX_W;
  localparam int PAD_A = ADDR_W - IDX_W;

  assign in_range_o  = index_i < {{PAD_M{1'b0}}, size_i};
  assign elem_addr_o = base_i + {{PAD_A{1'b0}}, index_i[IDX_W-1:0]};
endmodule

// File: rtl/rtr_fault_latch.sv
module rtr_fault_latch #(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [1:0]       cause_i,
  input  logic [IDX_W-1:0] index_i,
  output logic             irq_o,
  output logic [1:0]       cause_o,
  output logic [IDX_W-1:0] fault_index_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o         <= 1'b0;
      cause_o       <= 2'b00;
      fault_index_o <= '0;
    end else begin
      irq_o <= set_i;
      if (set_i) begin
        cause_o       <= cause_i;
        fault_index_o <= index_i;
      end
    end
  end

  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(fault_index_o) && $stable(cause_o)); // R10
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cause_o != 2'b00); // R7
endmodule

// File: rtl/rtr_resolver.sv
module rtr_resolver
  import rtr_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int ADDR_W = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_desc_call_i,
  input  logic [IDX_W-1:0]         req_index_i,
  input  logic [ADDR_W-1:0]        table_base_i,
  input  logic [rtr_pkg::MANT_W-1:0] stk_index_i,
  output logic                     mem_req_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic [rtr_pkg::WORD_W-1:0] mem_rdata_i,
  output logic                     push_o,
  output logic [rtr_pkg::WORD_W-1:0] push_data_o,
  output logic                     pop_o,
  output logic                     branch_o,
  output logic [ADDR_W-1:0]        branch_addr_o,
  output logic                     done_o,
  output logic                     irq_o,
  output logic [1:0]               irq_cause_o,
  output logic [IDX_W-1:0]         fault_index_o
);
  localparam int SIZE_LO = POS_SIZE_HI - IDX_W + 1;
  localparam int PAD_A   = ADDR_W - IDX_W;

  state_e              state_q;
  logic [IDX_W-1:0]    idx_q;
  logic                call_q;
  logic [MANT_W-1:0]   mant_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                indexed_q;

  logic                in_range;
  logic [ADDR_W-1:0]   elem_addr;
  act_e                act;
  logic                tbl_hit;
  logic                fault_set;
  logic [1:0]          fault_cause;

  function automatic logic [WORD_W-1:0] mk_ref(input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_FLAG] = 1'b1;
    w[POS_PRES] = 1'b1;
    w[ADDR_W-1:0] = a;
    return w;
  endfunction

  rtr_bounds #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .MANT_W(MANT_W)) i_bounds (
    .index_i     (mant_q),
    .size_i      (mem_rdata_i[POS_SIZE_HI:SIZE_LO]),
    .base_i      (mem_rdata_i[ADDR_W-1:0]),
    .in_range_o  (in_range),
    .elem_addr_o (elem_addr)
  );

  rtr_classify i_classify (
    .flag_i      (mem_rdata_i[POS_FLAG]),
    .kind_i      (mem_rdata_i[POS_KIND_LO+1:POS_KIND_LO]),
    .present_i   (mem_rdata_i[POS_PRES]),
    .desc_call_i (call_q),
    .in_range_i  (in_range),
    .act_o       (act)
  );

  assign tbl_hit     = (state_q == ST_TBL_WAIT) && mem_rvalid_i;
  assign fault_set   = tbl_hit && (act == ACT_FAULT_BOUNDS || act == ACT_FAULT_ABSENT);
  assign fault_cause = (act == ACT_FAULT_BOUNDS) ? CAUSE_BOUNDS : CAUSE_ABSENT;

  rtr_fault_latch #(.IDX_W(IDX_W)) i_fault (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .set_i         (fault_set),
    .cause_i       (fault_cause),
    .index_i       (idx_q),
    .irq_o         (irq_o),
    .cause_o       (irq_cause_o),
    .fault_index_o (fault_index_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_TBL_REQ) || (state_q == ST_DAT_REQ);
  assign mem_addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      idx_q         <= '0;
      call_q        <= 1'b0;
      mant_q        <= '0;
      addr_q        <= '0;
      indexed_q     <= 1'b0;
      push_o        <= 1'b0;
      push_data_o   <= '0;
      pop_o         <= 1'b0;
      branch_o      <= 1'b0;
      branch_addr_o <= '0;
      done_o        <= 1'b0;
    end else begin
      push_o   <= 1'b0;
      pop_o    <= 1'b0;
      branch_o <= 1'b0;
      done_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          idx_q   <= req_index_i;
          call_q  <= req_desc_call_i;
          mant_q  <= stk_index_i;
          addr_q  <= table_base_i + {{PAD_A{1'b0}}, req_index_i};
          state_q <= ST_TBL_REQ;
        end
        ST_TBL_REQ: state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rvalid_i) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          unique case (act)
            ACT_PUSH_ENTRY: begin
              push_o      <= 1'b1;
              push_data_o <= mem_rdata_i;
            end
            ACT_PUSH_BUILT: begin
              push_o      <= 1'b1;
              push_data_o <= mk_ref(addr_q);
            end
            ACT_PUSH_ELEM_DESC: begin
              push_o      <= 1'b1;
              pop_o       <= 1'b1;
              push_data_o <= mk_ref(elem_addr);
            end
            ACT_READ_DIRECT: begin
              done_o    <= 1'b0;
              addr_q    <= mem_rdata_i[ADDR_W-1:0];
              indexed_q <= 1'b0;
              state_q   <= ST_DAT_REQ;
            end
            ACT_READ_ELEM: begin
              done_o    <= 1'b0;
              addr_q    <= elem_addr;
              indexed_q <= 1'b1;
              state_q   <= ST_DAT_REQ;
            end
            ACT_BRANCH: begin
              branch_o      <= 1'b1;
              branch_addr_o <= mem_rdata_i[ADDR_W-1:0];
            end
            default: ;
          endcase
        end
        ST_DAT_REQ: state_q <= ST_DAT_WAIT;
        ST_DAT_WAIT: if (mem_rvalid_i) begin
          push_o      <= 1'b1;
          push_data_o <= mem_rdata_i;
          pop_o       <= indexed_q;
          done_o      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_READ_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_RESULT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o || branch_o || irq_o) |-> done_o); // R3
  AST_POP_WITH_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> push_o); // R6
  AST_FAULT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !push_o && !pop_o && !branch_o); // R7
  AST_FAULT_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> fault_index_o == idx_q); // R9
  AST_BRANCH_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |-> !push_o && !irq_o); // R8
endmodule

// File: tb/test_rtr_resolver.sv
`timescale 1ns/1ps
module test_rtr_resolver;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_desc_call_i = 1'b0;
  logic [9:0]  req_index_i = '0;
  logic [14:0] table_base_i = 15'h0020;
  logic [38:0] stk_index_i = '0;
  logic        mem_req_o;
  logic [14:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [47:0] mem_rdata_i = '0;
  logic        push_o;
  logic [47:0] push_data_o;
  logic        pop_o;
  logic        branch_o;
  logic [14:0] branch_addr_o;
  logic        done_o;
  logic        irq_o;
  logic [1:0]  irq_cause_o;
  logic [9:0]  fault_index_o;

  int checks = 0;
  int failures = 0;
  logic [47:0] mem [256];

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    mem_rvalid_i <= mem_req_o;
    mem_rdata_i  <= mem[mem_addr_o[7:0]];
  end

  rtr_resolver i_rtr_resolver (.*);

  bit          r_push, r_pop, r_branch, r_irq, r_busy;
  logic [47:0] r_data;
  logic [14:0] r_baddr;
  logic [1:0]  r_cause;
  logic [14:0] r_addr [4];
  int          r_nreq, r_lat;

  function automatic logic [47:0] mk(input logic [1:0] kind, input bit pres,
                                     input logic [9:0] size, input logic [14:0] base);
    return {1'b1, kind, pres, size, 19'b0, base};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit dc, input logic [9:0] idx, input logic [38:0] sec);
    int cyc;
    r_push = 0; r_pop = 0; r_branch = 0; r_irq = 0; r_nreq = 0; r_lat = -1;
    r_data = '0; r_baddr = '0; r_cause = '0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_desc_call_i = dc; req_index_i = idx; stk_index_i = sec;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    r_busy = !req_ready_o;
    cyc = 1;
    while (cyc < 20) begin
      if (mem_req_o && r_nreq < 4) begin
        r_addr[r_nreq] = mem_addr_o;
        r_nreq++;
      end
      if (push_o)   begin r_push = 1; r_data = push_data_o; end
      if (pop_o)    r_pop = 1;
      if (branch_o) begin r_branch = 1; r_baddr = branch_addr_o; end
      if (irq_o)    begin r_irq = 1; r_cause = irq_cause_o; end
      if (done_o) begin
        r_lat = cyc - 1;
        break;
      end
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R1 ready", req_ready_o, 1);
    chk({push_o, pop_o, branch_o, irq_o, done_o, mem_req_o} == 6'b0, "R1 strobes",
        {push_o, pop_o, branch_o, irq_o, done_o, mem_req_o}, 0);
    chk(fault_index_o == 10'd0, "R1 fault_index", fault_index_o, 0);
  endtask

  task automatic t_operand();
    run(1'b0, 10'd3, '0);
    chk(r_busy, "R2 busy", r_busy, 1);
    chk(r_nreq == 1 && r_addr[0] == 15'h0023, "R2 table addr", r_addr[0], 15'h0023);
    chk(r_push && r_data == 48'h0000_0ABC_DEF1, "R3 push operand", r_data, 48'h0000_0ABC_DEF1);
    chk(r_lat == 2 && !r_pop, "R3 latency", r_lat, 2);
    run(1'b1, 10'd3, '0);
    chk(r_push && r_data == mk(2'b00, 1'b1, 10'd0, 15'h0023), "R4 built desc",
        r_data, mk(2'b00, 1'b1, 10'd0, 15'h0023));
    chk(r_lat == 2, "R4 latency", r_lat, 2);
  endtask

  task automatic t_direct();
    run(1'b0, 10'd4, '0);
    chk(r_nreq == 2 && r_addr[1] == 15'h0050, "R5 second read addr", r_addr[1], 15'h0050);
    chk(r_push && r_data == 48'h0000_0000_7777 && r_lat == 4, "R5 indirect push", r_data, 48'h7777);
    run(1'b1, 10'd4, '0);
    chk(r_push && r_data == mk(2'b00, 1'b1, 10'd0, 15'h0050) && r_lat == 2 && r_nreq == 1,
        "R5 desc call unchanged", r_data, mk(2'b00, 1'b1, 10'd0, 15'h0050));
  endtask

  task automatic t_array();
    run(1'b0, 10'd5, 39'd3);
    chk(r_push && r_pop && r_data == 48'h4242 && r_lat == 4, "R6 indexed fetch", r_data, 48'h4242);
    chk(r_addr[1] == 15'h0063, "R6 element addr", r_addr[1], 15'h0063);
    run(1'b1, 10'd5, 39'd3);
    chk(r_push && r_pop && r_lat == 2 && r_data == mk(2'b00, 1'b1, 10'd0, 15'h0063),
        "R6 indexed desc", r_data, mk(2'b00, 1'b1, 10'd0, 15'h0063));
    run(1'b0, 10'd5, 39'd4);
    chk(r_push && r_data == 48'h4343, "R6 last element", r_data, 48'h4343);
    run(1'b0, 10'd5, 39'd5);
    chk(r_irq && r_cause == 2'b01 && !r_push && !r_pop, "R7 bound fault", r_cause, 2'b01);
    chk(r_nreq == 1 && r_lat == 2, "R7 no second read", r_nreq, 1);
    chk(fault_index_o == 10'd5, "R7 fault index", fault_index_o, 5);
    run(1'b1, 10'd5, 39'h40_0000_0003);
    chk(r_irq && r_cause == 2'b01 && !r_push, "R7 large index", r_cause, 2'b01);
  endtask

  task automatic t_prog();
    run(1'b0, 10'd6, '0);
    chk(r_branch && r_baddr == 15'h1234 && !r_push && r_lat == 2, "R8 branch op call", r_baddr, 15'h1234);
    run(1'b1, 10'd6, '0);
    chk(r_branch && r_baddr == 15'h1234 && !r_push, "R8 branch desc call", r_baddr, 15'h1234);
    run(1'b0, 10'd7, '0);
    chk(r_irq && r_cause == 2'b10 && !r_branch, "R9 absent segment", r_cause, 2'b10);
    chk(fault_index_o == 10'd7, "R9 fault index", fault_index_o, 7);
  endtask

  task automatic t_hold();
    run(1'b0, 10'd3, '0);
    chk(!r_irq && fault_index_o == 10'd7 && irq_cause_o == 2'b10, "R10 hold", fault_index_o, 7);
  endtask

  task automatic t_wrap();
    table_base_i = 15'h7FF8;
    run(1'b0, 10'h010, '0);
    chk(r_addr[0] == 15'h0008 && r_data == 48'h55, "R2 base wrap", r_addr[0], 15'h0008);
    table_base_i = 15'h0020;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h23] = 48'h0000_0ABC_DEF1;
    mem[8'h24] = mk(2'b00, 1'b1, 10'd0, 15'h0050);
    mem[8'h50] = 48'h0000_0000_7777;
    mem[8'h25] = mk(2'b01, 1'b1, 10'd5, 15'h0060);
    mem[8'h63] = 48'h4242;
    mem[8'h64] = 48'h4343;
    mem[8'h26] = mk(2'b10, 1'b1, 10'd0, 15'h1234);
    mem[8'h27] = mk(2'b10, 1'b0, 10'd0, 15'h0200);
    mem[8'h08] = 48'h55;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_operand();
    t_direct();
    t_array();
    t_prog();
    t_hold();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule